// File: doc/BRIEF.md
# Per-Lane Segment Address Extender

This unit sits on the memory side of a narrow processor-to-memory link whose processor is split into several narrow lanes. Each lane presents only a short offset. The unit holds, for every lane, two segment registers: one for instruction fetches and one for data references. It forms a full physical address by placing the selected segment value in the high-order bits and the lane's offset in the low-order bits. No wire says which segment register applies. Both sides follow the same fixed ordering instead: each lane alternates strictly between a fetch slot and a data slot, and every lane starts at a fetch slot after reset.

A segment value is wider than one narrow transfer, so it is loaded in two pieces through a separate load port. The low piece goes first, into a shared staging register. The target register changes only when the matching high piece arrives as the very next load write. A reference may also request an advance, used for stepping through sequential addresses. The offset is incremented by one. If that increment wraps past the end of the segment, the selected segment register steps up by one and a carry flag goes out together with that reference.

Requesting lanes are granted one per cycle in rotating order. Each granted reference appears on the memory-side outputs one clock later.

Top module: `seg_addr_unit`

## Requirements
- R1: After reset, the memory outputs are idle (`mem_valid` and `mem_carry` low), every segment register holds zero, every lane's next slot is a fetch, and lane 0 has first priority.
- R2: A granted reference with `req_adv` low produces, one clock after the grant, `mem_valid` high, `mem_lane` set to the lane, and `mem_addr` = {selected segment (high ADDR_W-LANE_W bits), lane offset (low LANE_W bits)}.
- R3: Each lane's granted references alternate fetch, data, fetch, and so on. A fetch uses the lane's instruction segment and shows `mem_fetch`=1. A data reference uses the lane's data segment and shows `mem_fetch`=0.
- R4: A lane that is not granted keeps its fetch/data position, whether it is idle or loses arbitration.
- R5: At most one lane is granted per cycle, and only a requesting lane. The grant goes to the first requesting lane after the most recently granted lane, searching upward in index and wrapping around.
- R6: A segment load is a load write with `ld_high`=0, carrying the low half (bits HALF_W-1:0), followed directly on the next load write by `ld_high`=1 with the same lane and the same `ld_dsel`, carrying the upper bits. `ld_dsel`=1 selects the data segment and 0 selects the instruction segment. The register takes the new value at that second write, and a reference granted on any later cycle uses it.
- R7: A high-half write with no staged low half, or whose lane or `ld_dsel` differs from the staged one, changes no segment register and discards the staged half.
- R8: A reference with `req_adv`=1 uses offset+1. When the offset is all ones, the address carries the segment plus one with a zero offset, and the selected segment register keeps that incremented value for later references.
- R9: `mem_carry` is high only in the output cycle of the reference whose advance wrapped. It is low on any other cycle.
- R10: When a segment load completes in the same cycle as a wrapping advance on the same register, that reference's address uses the old segment plus one, and the register ends up holding the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NLANES | Per-lane reference request |
| req_off | input | NLANES*LANE_W | Per-lane offsets; lane i occupies bits i*LANE_W +: LANE_W |
| req_adv | input | NLANES | Per-lane advance (add one with carry into segment) |
| req_gnt | output | NLANES | One-hot grant, valid in the same cycle as the request |
| ld_valid | input | 1 | Segment load write strobe |
| ld_lane | input | clog2(NLANES) | Lane whose segment is loaded |
| ld_dsel | input | 1 | 1 = data segment, 0 = instruction segment |
| ld_high | input | 1 | 0 = low half, 1 = high half (commits) |
| ld_piece | input | HALF_W | Segment half value |
| mem_valid | output | 1 | Physical reference issued |
| mem_lane | output | clog2(NLANES) | Lane of the issued reference |
| mem_fetch | output | 1 | 1 = instruction fetch slot, 0 = data slot |
| mem_addr | output | ADDR_W | Physical address |
| mem_carry | output | 1 | Advance crossed a segment boundary |

## Verification
`req_gnt` is combinational, so the bench reads it shortly after driving a request on the falling edge, before the next rising edge. Every `mem_*` output is registered once. It is therefore checked just after the rising edge that samples the request, and `mem_valid` and `mem_carry` are checked again one edge later to confirm they have dropped. A segment load is visible only to a reference granted on an edge after its high-half write. The bench runs its tests one after another, in series, and follows each lane's fetch/data position and segment values in its own model.

// File: rtl/seg_addr_unit.sv
module seg_addr_unit #(
  parameter int NLANES = 4,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 32,
  localparam int SEG_W  = ADDR_W - LANE_W,
  localparam int HALF_W = (SEG_W + 1) / 2,
  localparam int LW     = $clog2(NLANES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLANES-1:0]        req_valid,
  input  logic [NLANES*LANE_W-1:0] req_off,
  input  logic [NLANES-1:0]        req_adv,
  output logic [NLANES-1:0]        req_gnt,
  input  logic                     ld_valid,
  input  logic [LW-1:0]            ld_lane,
  input  logic                     ld_dsel,
  input  logic                     ld_high,
  input  logic [HALF_W-1:0]        ld_piece,
  output logic                     mem_valid,
  output logic [LW-1:0]            mem_lane,
  output logic                     mem_fetch,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     mem_carry
);

  logic [SEG_W-1:0]  iseg [NLANES];
  logic [SEG_W-1:0]  dseg [NLANES];
  logic [NLANES-1:0] tog;
  logic [LW-1:0]     last;

  logic [HALF_W-1:0] stg;
  logic              stg_v;
  logic [LW-1:0]     stg_lane;
  logic              stg_dsel;

  logic              gnt_any;
  logic [LW-1:0]     glane;

  always_comb begin
    gnt_any = 1'b0;
    glane   = '0;
    for (int k = 1; k <= NLANES; k++) begin
      int i;
      i = (int'(last) + k) % NLANES;
      if (!gnt_any && req_valid[i]) begin
        gnt_any = 1'b1;
        glane   = LW'(i);
      end
    end
  end

  assign req_gnt = gnt_any ? (NLANES'(1) << glane) : '0;

  logic [LANE_W-1:0] goff;
  logic              gdata;
  logic [SEG_W-1:0]  gseg;
  logic [LANE_W:0]   sum;
  logic              carry;
  logic [SEG_W-1:0]  oseg;

  assign goff  = req_off[glane*LANE_W +: LANE_W];
  assign gdata = tog[glane];
  assign gseg  = gdata ? dseg[glane] : iseg[glane];
  assign sum   = {1'b0, goff} + {{LANE_W{1'b0}}, req_adv[glane]};
  assign carry = sum[LANE_W];
  assign oseg  = gseg + {{(SEG_W-1){1'b0}}, carry};

  logic             commit;
  logic [SEG_W-1:0] newseg;

  assign commit = ld_valid && ld_high && stg_v &&
                  (stg_lane == ld_lane) && (stg_dsel == ld_dsel);
  assign newseg = SEG_W'({ld_piece, stg});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLANES; i++) begin
        iseg[i] <= '0;
        dseg[i] <= '0;
      end
      tog       <= '0;
      last      <= LW'(NLANES - 1);
      stg       <= '0;
      stg_v     <= 1'b0;
      stg_lane  <= '0;
      stg_dsel  <= 1'b0;
      mem_valid <= 1'b0;
      mem_lane  <= '0;
      mem_fetch <= 1'b0;
      mem_addr  <= '0;
      mem_carry <= 1'b0;
    end else begin
      mem_valid <= gnt_any;
      mem_carry <= gnt_any && carry;
      if (gnt_any) begin
        mem_lane    <= glane;
        mem_fetch   <= !gdata;
        mem_addr    <= {oseg, sum[LANE_W-1:0]};
        last        <= glane;
        tog[glane]  <= !gdata;
        if (carry) begin
          if (gdata) dseg[glane] <= oseg;
          else       iseg[glane] <= oseg;
        end
      end
      if (ld_valid) begin
        if (!ld_high) begin
          stg      <= ld_piece;
          stg_v    <= 1'b1;
          stg_lane <= ld_lane;
          stg_dsel <= ld_dsel;
        end else begin
          stg_v <= 1'b0;
        end
      end
      if (commit) begin
        if (ld_dsel) dseg[ld_lane] <= newseg;
        else         iseg[ld_lane] <= newseg;
      end
    end
  end

endmodule

// File: rtl/seg_addr_unit_chk.sv
module seg_addr_unit_chk #(
  parameter int NLANES = 4,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 32,
  localparam int LW = $clog2(NLANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLANES-1:0] req_valid,
  input logic [NLANES-1:0] req_gnt,
  input logic              mem_valid,
  input logic [LW-1:0]     mem_lane,
  input logic              mem_fetch,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_carry
);

  a_r5_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_gnt));

  a_r5_gnt_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (req_gnt & ~req_valid) == '0);

  a_r2_issue_follows_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_gnt) |=> mem_valid);

  a_r2_idle_follows_none: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_gnt) |=> !mem_valid);

  a_r3_slots_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && $past(mem_valid) && mem_lane == $past(mem_lane))
      |-> mem_fetch != $past(mem_fetch));

  a_r9_carry_with_issue: assert property (@(posedge clk) disable iff (!rst_n)
    mem_carry |-> mem_valid);

  a_r8_carry_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
    mem_carry |-> mem_addr[LANE_W-1:0] == '0);

endmodule

bind seg_addr_unit seg_addr_unit_chk #(
  .NLANES(NLANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_gnt(req_gnt),
  .mem_valid(mem_valid), .mem_lane(mem_lane), .mem_fetch(mem_fetch),
  .mem_addr(mem_addr), .mem_carry(mem_carry)
);

// File: tb/seg_addr_unit_bench.sv
`timescale 1ns/1ps
module seg_addr_unit_bench;
  localparam int NL = 4;
  localparam int LW = 8;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] req_valid = '0;
  logic [NL*LW-1:0] req_off = '0;
  logic [NL-1:0] req_adv = '0;
  logic [NL-1:0] req_gnt;
  logic          ld_valid = 1'b0;
  logic [1:0]    ld_lane = '0;
  logic          ld_dsel = 1'b0;
  logic          ld_high = 1'b0;
  logic [11:0]   ld_piece = '0;
  logic          mem_valid;
  logic [1:0]    mem_lane;
  logic          mem_fetch;
  logic [AW-1:0] mem_addr;
  logic          mem_carry;

  seg_addr_unit #(.NLANES(NL), .LANE_W(LW), .ADDR_W(AW)) u_seg_addr_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_off(req_off),
    .req_adv(req_adv), .req_gnt(req_gnt), .ld_valid(ld_valid),
    .ld_lane(ld_lane), .ld_dsel(ld_dsel), .ld_high(ld_high),
    .ld_piece(ld_piece), .mem_valid(mem_valid), .mem_lane(mem_lane),
    .mem_fetch(mem_fetch), .mem_addr(mem_addr), .mem_carry(mem_carry)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [23:0] m_iseg [NL];
  logic [23:0] m_dseg [NL];
  bit          m_tog [NL];
  int          m_last = NL - 1;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    req_valid = '0; req_off = '0; req_adv = '0;
    ld_valid = 1'b0; ld_high = 1'b0; ld_dsel = 1'b0; ld_lane = '0; ld_piece = '0;
  endtask

  task automatic ld_write(int lane, bit dsel, bit high, logic [11:0] piece);
    @(negedge clk);
    clear_in();
    ld_valid = 1'b1; ld_lane = 2'(lane); ld_dsel = dsel;
    ld_high = high; ld_piece = piece;
    @(posedge clk);
  endtask

  task automatic load_seg(int lane, bit dsel, logic [23:0] val);
    ld_write(lane, dsel, 1'b0, val[11:0]);
    ld_write(lane, dsel, 1'b1, val[23:12]);
    @(negedge clk);
    clear_in();
    if (dsel) m_dseg[lane] = val; else m_iseg[lane] = val;
  endtask

  task automatic expect_out(string req, int lane, logic [7:0] off, bit adv);
    logic [23:0] seg;
    logic [8:0]  sum;
    logic [23:0] oseg;
    seg  = m_tog[lane] ? m_dseg[lane] : m_iseg[lane];
    sum  = {1'b0, off} + 9'(adv);
    oseg = seg + 24'(sum[8]);
    chk({req, " valid"}, 64'(mem_valid), 64'd1);
    chk({req, " lane"}, 64'(mem_lane), 64'(lane));
    chk({req, " R3 slot"}, 64'(mem_fetch), 64'(!m_tog[lane]));
    chk({req, " addr"}, 64'(mem_addr), 64'({oseg, sum[7:0]}));
    chk({req, " R9 carry"}, 64'(mem_carry), 64'(sum[8]));
    if (sum[8]) begin
      if (m_tog[lane]) m_dseg[lane] = oseg; else m_iseg[lane] = oseg;
    end
    m_tog[lane] = !m_tog[lane];
    m_last = lane;
  endtask

  task automatic ref1(string req, int lane, logic [7:0] off, bit adv);
    @(negedge clk);
    clear_in();
    req_valid[lane] = 1'b1;
    req_off[lane*LW +: LW] = off;
    req_adv[lane] = adv;
    #1 chk({req, " R5 gnt"}, 64'(req_gnt), 64'(1 << lane));
    @(posedge clk); #1;
    expect_out(req, lane, off, adv);
    @(negedge clk);
    clear_in();
    @(posedge clk); #1;
    chk({req, " R9 idle valid"}, 64'(mem_valid), 64'd0);
    chk({req, " R9 idle carry"}, 64'(mem_carry), 64'd0);
  endtask

  task automatic rr(logic [NL-1:0] mask, int cycles);
    for (int c = 0; c < cycles; c++) begin
      int exp_lane;
      exp_lane = -1;
      for (int k = 1; k <= NL; k++) begin
        int i;
        i = (m_last + k) % NL;
        if (exp_lane < 0 && mask[i]) exp_lane = i;
      end
      @(negedge clk);
      clear_in();
      req_valid = mask;
      for (int i = 0; i < NL; i++) req_off[i*LW +: LW] = 8'(8'h80 + i);
      #1 chk("R5 rotating grant", 64'(req_gnt), 64'(1 << exp_lane));
      @(posedge clk); #1;
      expect_out("R5 rotating issue", exp_lane, 8'(8'h80 + exp_lane), 1'b0);
    end
    @(negedge clk);
    clear_in();
    @(posedge clk);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NL; i++) begin
      m_iseg[i] = '0; m_dseg[i] = '0; m_tog[i] = 1'b0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset valid", 64'(mem_valid), 64'd0);
    chk("R1 reset carry", 64'(mem_carry), 64'd0);
    chk("R1 reset gnt", 64'(req_gnt), 64'd0);
    ref1("R1 first fetch", 0, 8'h42, 1'b0);
  endtask

  task automatic t_basic();
    load_seg(1, 1'b0, 24'h123456);
    load_seg(1, 1'b1, 24'hABCDEF);
    ref1("R6 R2 fetch", 1, 8'h10, 1'b0);
    ref1("R6 R2 data", 1, 8'h20, 1'b0);
    ref1("R3 fetch again", 1, 8'h30, 1'b0);
  endtask

  task automatic t_bad_load();
    ld_write(2, 1'b0, 1'b1, 12'hFFF);
    ld_write(2, 1'b1, 1'b0, 12'h111);
    ld_write(2, 1'b0, 1'b1, 12'h222);
    ld_write(2, 1'b1, 1'b1, 12'h333);
    @(negedge clk);
    clear_in();
    ref1("R7 fetch seg kept", 2, 8'h01, 1'b0);
    ref1("R7 data seg kept", 2, 8'h02, 1'b0);
  endtask

  task automatic t_rr();
    rr(4'b1111, 6);
    rr(4'b0101, 4);
    ref1("R4 lane1 slot kept", 1, 8'h05, 1'b0);
    ref1("R4 lane3 slot kept", 3, 8'h06, 1'b0);
  endtask

  task automatic t_carry();
    load_seg(3, 1'b1, 24'h0000FF);
    if (!m_tog[3]) ref1("R8 align", 3, 8'h00, 1'b0);
    ref1("R8 wrap", 3, 8'hFF, 1'b1);
    ref1("R8 fetch between", 3, 8'h07, 1'b0);
    ref1("R8 seg kept plus one", 3, 8'h10, 1'b1);
  endtask

  task automatic t_commit_vs_carry();
    if (!m_tog[3]) ref1("R10 align", 3, 8'h00, 1'b0);
    ld_write(3, 1'b1, 1'b0, 12'h555);
    @(negedge clk);
    clear_in();
    ld_valid = 1'b1; ld_lane = 2'd3; ld_dsel = 1'b1; ld_high = 1'b1; ld_piece = 12'h0AA;
    req_valid[3] = 1'b1;
    req_off[3*LW +: LW] = 8'hFF;
    req_adv[3] = 1'b1;
    @(posedge clk); #1;
    expect_out("R10 wrap with load", 3, 8'hFF, 1'b1);
    m_dseg[3] = 24'h0AA555;
    @(negedge clk);
    clear_in();
    ref1("R10 fetch", 3, 8'h00, 1'b0);
    ref1("R10 loaded value wins", 3, 8'h01, 1'b0);
  endtask

  initial begin
    clear_in();
    t_reset();
    t_basic();
    t_bad_load();
    t_rr();
    t_carry();
    t_commit_vs_carry();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule